// File: doc/BRIEF.md
# Single-Entry Loop Branch Target Predictor

This block sits beside the fetch stage of an in-order pipeline and remembers one taken backward branch: its address and its destination. The most recent taken backward branch is almost always the closing branch of a tight loop. When fetch reaches that address again, the block raises a predict-taken flag and presents the stored destination in the same cycle. Fetch can then jump straight to the top of the loop and skip the one-cycle bubble that a taken branch otherwise costs. Restarting the pipeline after a wrong guess is the job of the surrounding core.

The block receives four kinds of input:
- the fetch address;
- a branch resolution report, qualified by a valid strobe;
- a pulse when the instruction stream is synchronised (fence.i);
- a pulse when a trap is taken.

The resolution report is a push-only flow. Each report is taken in the cycle its valid strobe is high, and the block never applies back-pressure, so it has no ready signal. The lookup outputs are combinational and carry no handshake.

The entry is written only by a branch that resolves taken with a destination strictly below its own address. It is cleared in three cases:
- a branch it predicted resolves not-taken;
- fence.i;
- a trap.

If an allocation and a clear fall in the same cycle, the clear wins.

Top module: `btb1_predictor`

## Requirements
- R1: While reset is held and after it is released, with no allocation yet, `pred_taken` is 0 and `pred_target` is all zeroes for every fetch address.
- R2: In the same cycle, `pred_taken` is 1 exactly when the entry is valid and `fetch_addr` equals the stored branch address in all bits. On a hit `pred_target` equals the stored target; otherwise `pred_target` is all zeroes.
- R3: A report with `br_valid`=1, `br_taken`=1 and `br_target` < `br_pc` (unsigned compare) writes `br_pc` and `br_target` into the entry and sets it valid. The write is visible from the next cycle and replaces any earlier entry. A target equal to the branch address does not count as backward.
- R4: A report with `br_valid`=1 and `br_taken`=0 whose `br_pc` equals the address of a valid entry invalidates the entry from the next cycle.
- R5: `fencei`=1 invalidates the entry from the next cycle.
- R6: `trap`=1 invalidates the entry from the next cycle.
- R7: When an invalidation (R4, R5 or R6) and an allocation (R3) happen in the same cycle, the entry is invalid in the next cycle.
- R8: A taken report whose target is at or above its address leaves the entry unchanged. So does a not-taken report whose address differs from the entry.
- R9: In a cycle with no valid report, no `fencei` and no `trap`, the entry is unchanged. The next cycle's prediction for the same fetch address therefore repeats.
- R10: While `br_valid`=0, the values on `br_pc`, `br_target` and `br_taken` have no effect on the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | AW | Address being fetched this cycle |
| br_valid | input | 1 | A branch resolution report is present |
| br_pc | input | AW | Address of the resolved branch |
| br_target | input | AW | Destination of the resolved branch |
| br_taken | input | 1 | 1 if the branch resolved taken |
| fencei | input | 1 | Instruction-stream synchronisation event |
| trap | input | 1 | Trap taken this cycle |
| pred_taken | output | 1 | Fetch address hits the valid entry |
| pred_target | output | AW | Predicted destination on a hit, zero otherwise |

## Verification
The hardest situation to create is a clash in one cycle: a backward taken report arriving together with fence.i or a trap. Also hard are a not-taken report that lands exactly on the stored address, and a backward branch whose target equals its own address. Random traffic rarely lines these up. The stimulus therefore steers them directly. It draws all addresses from a small pool of eight word-aligned values, so that fetch and branch addresses repeatedly collide with the stored entry. It adds directed sequences for each clash and for the equal-address boundary. A bench-side model of the entry supplies the expected prediction in every cycle.

// File: rtl/btb1_pkg.sv
package btb1_pkg;

  // Update decision applied to the single entry at the next clock edge.
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_FILL = 2'd1,
    UPD_KILL = 2'd2
  } upd_e;

endpackage

// File: rtl/btb1_update_ctrl.sv
module btb1_update_ctrl
  import btb1_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_target,
  input  logic          br_taken,
  input  logic          fencei,
  input  logic          trap,
  input  logic          ent_valid,
  input  logic [AW-1:0] ent_addr,
  output upd_e          action
);

  logic backward;
  logic mispredict;
  logic kill;
  logic fill;

  always_comb begin
    // Strictly lower destination: equal address is not a loop.
    backward   = (br_target < br_pc);
    // Entry predicted this branch taken, but it fell through.
    mispredict = br_valid && !br_taken && ent_valid && (br_pc == ent_addr);
    kill       = fencei || trap || mispredict;
    fill       = br_valid && br_taken && backward;
    // Invalidation outranks allocation.
    if (kill)      action = UPD_KILL;
    else if (fill) action = UPD_FILL;
    else           action = UPD_HOLD;
  end

endmodule

// File: rtl/btb1_entry.sv
module btb1_entry
  import btb1_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  upd_e          action,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_target,
  output logic          ent_valid,
  output logic [AW-1:0] ent_addr,
  output logic [AW-1:0] ent_target
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_addr   <= '0;
      ent_target <= '0;
    end else begin
      unique case (action)
        UPD_KILL: ent_valid <= 1'b0;
        UPD_FILL: begin
          ent_valid  <= 1'b1;
          ent_addr   <= wr_addr;
          ent_target <= wr_target;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/btb1_lookup.sv
module btb1_lookup #(
  parameter int AW = 32
) (
  input  logic          ent_valid,
  input  logic [AW-1:0] ent_addr,
  input  logic [AW-1:0] ent_target,
  input  logic [AW-1:0] fetch_addr,
  output logic          hit,
  output logic [AW-1:0] hit_target
);

  always_comb begin
    hit        = ent_valid && (fetch_addr == ent_addr);
    hit_target = hit ? ent_target : '0;
  end

endmodule

// File: rtl/btb1_predictor.sv
module btb1_predictor
  import btb1_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_target,
  input  logic          br_taken,
  input  logic          fencei,
  input  logic          trap,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target
);

  upd_e          action;
  logic          ent_valid;
  logic [AW-1:0] ent_addr;
  logic [AW-1:0] ent_target;

  btb1_update_ctrl #(.AW(AW)) ctrl_i (
    .br_valid  (br_valid),
    .br_pc     (br_pc),
    .br_target (br_target),
    .br_taken  (br_taken),
    .fencei    (fencei),
    .trap      (trap),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .action    (action)
  );

  btb1_entry #(.AW(AW)) entry_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .action     (action),
    .wr_addr    (br_pc),
    .wr_target  (br_target),
    .ent_valid  (ent_valid),
    .ent_addr   (ent_addr),
    .ent_target (ent_target)
  );

  btb1_lookup #(.AW(AW)) lookup_i (
    .ent_valid  (ent_valid),
    .ent_addr   (ent_addr),
    .ent_target (ent_target),
    .fetch_addr (fetch_addr),
    .hit        (pred_taken),
    .hit_target (pred_target)
  );

endmodule

// File: rtl/btb1_predictor_chk.sv
module btb1_predictor_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_addr,
  input logic          br_valid,
  input logic [AW-1:0] br_pc,
  input logic [AW-1:0] br_target,
  input logic          br_taken,
  input logic          fencei,
  input logic          trap,
  input logic          pred_taken,
  input logic [AW-1:0] pred_target
);

  // R2: a miss never drives a stale target
  assert_miss_zero_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (pred_target == '0));

  // R3: a clean backward fill is hit next cycle at its own address
  assert_fill_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken && (br_target < br_pc) && !fencei && !trap)
    |=> ((fetch_addr != $past(br_pc)) ||
         (pred_taken && (pred_target == $past(br_target)))));

  // R4: fall-through of the predicted branch clears the entry
  assert_mispredict_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken && pred_taken && (fetch_addr == br_pc)) |=> !pred_taken);

  // R5 R6 R7: fence.i or trap clears the entry, even beside a fill
  assert_event_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fencei || trap) |=> !pred_taken);

  // R8: forward taken report leaves the prediction untouched
  assert_forward_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken && !(br_target < br_pc) && !fencei && !trap)
    |=> ((fetch_addr != $past(fetch_addr)) ||
         ((pred_taken == $past(pred_taken)) && (pred_target == $past(pred_target)))));

  // R9: quiet cycle leaves the prediction untouched
  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !fencei && !trap)
    |=> ((fetch_addr != $past(fetch_addr)) ||
         ((pred_taken == $past(pred_taken)) && (pred_target == $past(pred_target)))));

endmodule

bind btb1_predictor btb1_predictor_chk #(.AW(AW)) chk_i (.*);

// File: tb/btb1_predictor_tb.sv
module btb1_predictor_tb_top;

  localparam int AW = 32;
  localparam int RAND_CYCLES = 3000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_pc = '0;
  logic [AW-1:0] br_target = '0;
  logic          br_taken = 1'b0;
  logic          fencei = 1'b0;
  logic          trap = 1'b0;
  logic          pred_taken;
  logic [AW-1:0] pred_target;

  int total = 0;
  int bad = 0;

  // bench model of the entry
  logic          m_valid = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_tgt = '0;

  always #10 clk = ~clk;  // 50 MHz

  btb1_predictor #(.AW(AW)) dut_i (.*);

  function automatic logic exp_hit(input logic [AW-1:0] fa);
    return m_valid && (fa == m_addr);
  endfunction

  function automatic logic [AW-1:0] exp_tgt(input logic [AW-1:0] fa);
    return exp_hit(fa) ? m_tgt : '0;
  endfunction

  task automatic model_step();
    logic kill;
    logic fill;
    kill = fencei || trap || (br_valid && !br_taken && m_valid && br_pc == m_addr);
    fill = br_valid && br_taken && (br_target < br_pc);
    if (kill) m_valid = 1'b0;
    else if (fill) begin
      m_valid = 1'b1;
      m_addr  = br_pc;
      m_tgt   = br_target;
    end
  endtask

  // Drive one cycle, check outputs against the model, then clock.
  task automatic cyc(input string req, input logic [AW-1:0] fa, input logic bv,
                     input logic [AW-1:0] pc, input logic [AW-1:0] tg,
                     input logic tk, input logic fi, input logic tp);
    @(negedge clk);
    fetch_addr = fa; br_valid = bv; br_pc = pc; br_target = tg;
    br_taken = tk; fencei = fi; trap = tp;
    #1;
    total++;
    if (pred_taken !== exp_hit(fa) || pred_target !== exp_tgt(fa)) begin
      bad++;
      $display("FAIL %s fa=%h actual taken=%b target=%h expected taken=%b target=%h",
               req, fa, pred_taken, pred_target, exp_hit(fa), exp_tgt(fa));
    end
    @(posedge clk);
    model_step();
  endtask

  function automatic logic [AW-1:0] pool_addr();
    return AW'(32'h100 + 32'(($urandom % 8) * 4));
  endfunction

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: checked while still in reset
    @(negedge clk); fetch_addr = 32'h100; #1;
    total++;
    if (pred_taken !== 1'b0 || pred_target !== '0) begin
      bad++;
      $display("FAIL R1 in reset actual=%b/%h expected=0/0", pred_taken, pred_target);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 32'h0,   0, 0, 0, 0, 0, 0);
    cyc("R1", 32'h100, 0, 0, 0, 0, 0, 0);
    // R3: backward fill, then hit and miss
    cyc("R3", 32'h0,   1, 32'h100, 32'h80, 1, 0, 0);
    cyc("R3", 32'h100, 0, 0, 0, 0, 0, 0);
    cyc("R2", 32'h104, 0, 0, 0, 0, 0, 0);
    // R8: forward taken and unrelated not-taken
    cyc("R8", 32'h100, 1, 32'h200, 32'h300, 1, 0, 0);
    cyc("R8", 32'h100, 1, 32'h40,  32'h0,   0, 0, 0);
    cyc("R8", 32'h100, 0, 0, 0, 0, 0, 0);
    cyc("R8", 32'h200, 0, 0, 0, 0, 0, 0);
    // R3 boundary: target equal to pc does not fill
    cyc("R3", 32'h100, 1, 32'h300, 32'h300, 1, 0, 0);
    cyc("R3", 32'h300, 0, 0, 0, 0, 0, 0);
    // R10: fields ignored while br_valid is low
    cyc("R10", 32'h100, 0, 32'h400, 32'h10, 1, 0, 0);
    cyc("R10", 32'h400, 0, 0, 0, 0, 0, 0);
    cyc("R10", 32'h100, 0, 32'h100, 32'h10, 0, 0, 0);
    cyc("R9",  32'h100, 0, 0, 0, 0, 0, 0);
    // R4: fall-through of the predicted branch
    cyc("R4", 32'h100, 1, 32'h100, 32'h80, 0, 0, 0);
    cyc("R4", 32'h100, 0, 0, 0, 0, 0, 0);
    // R5: fence.i
    cyc("R5", 32'h0,   1, 32'h180, 32'h120, 1, 0, 0);
    cyc("R5", 32'h180, 0, 0, 0, 0, 1, 0);
    cyc("R5", 32'h180, 0, 0, 0, 0, 0, 0);
    // R6: trap
    cyc("R6", 32'h0,   1, 32'h180, 32'h120, 1, 0, 0);
    cyc("R6", 32'h180, 0, 0, 0, 0, 0, 1);
    cyc("R6", 32'h180, 0, 0, 0, 0, 0, 0);
    // R7: clear beats fill in the same cycle
    cyc("R7", 32'h0,   1, 32'h500, 32'h20, 1, 1, 0);
    cyc("R7", 32'h500, 1, 32'h600, 32'h20, 1, 0, 1);
    cyc("R7", 32'h600, 0, 0, 0, 0, 0, 0);
    // R3: replacement of an older entry
    cyc("R3", 32'h0,   1, 32'h140, 32'h100, 1, 0, 0);
    cyc("R3", 32'h140, 1, 32'h160, 32'h104, 1, 0, 0);
    cyc("R3", 32'h140, 0, 0, 0, 0, 0, 0);
    cyc("R3", 32'h160, 0, 0, 0, 0, 0, 0);
    // R2 R9: constrained random traffic over a small address pool
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [AW-1:0] fa, pc, tg;
      logic bv, tk, fi, tp;
      fa = pool_addr();
      pc = pool_addr();
      tg = pool_addr();
      bv = ($urandom % 3) == 0;
      tk = ($urandom % 2) == 0;
      fi = ($urandom % 40) == 0;
      tp = ($urandom % 40) == 0;
      if (($urandom % 4) == 0 && m_valid) fa = m_addr;
      cyc("R2", fa, bv, pc, tg, tk, fi, tp);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule